// File: doc/BRIEF.md
# Per-Channel Gain and Zero Correction Engine

This block sits between the write port of a multi-channel converter and its per-channel DAC code registers. Every code written for a channel can be trimmed digitally. The block multiplies the code by a per-channel gain trim, adds a per-channel signed zero trim, and clamps the sum to the code range. A single enable bit selects correction or a one-cycle pass-through. When correction is off, the incoming code goes unchanged to the output, apart from the format conversion. The format conversion maps codes written in twos complement onto offset binary, so that both number formats reach the output as the same unsigned code.

Correction runs on one shared serial shift-and-add engine. The engine takes one cycle per gain bit. While it works, `busy` is high, and one more write can wait in a single holding slot. Writes that arrive while that slot is full are discarded. The downstream register file takes `out_vld`, `out_ch` and `out_code` as a write strobe and address.

Top module: `cal_corr_engine`

## Requirements
- R1: After reset, `out_vld` and `busy` are low, correction is disabled, every zero trim is 0 and every gain trim is FFFFh.
- R2: With correction disabled, a write accepted while idle appears on `out_vld`/`out_ch`/`out_code` on the next clock, with the code unchanged when `fmt_twos` is 0.
- R3: When `fmt_twos` is 1 during a write, bit 15 of the code is inverted (twos complement to offset binary) before any other processing.
- R4: With correction enabled, the result is floor(x × (gain + 1) / 65536) + zero, where x is the converted code, gain is unsigned and zero is signed. The result appears exactly 17 clocks after the write is accepted, on the write's own channel.
- R5: A corrected sum above 65535 is output as FFFFh.
- R6: A corrected sum below 0 is output as 0000h.
- R7: A trim write changes only the channel named by `trim_ch`. The other channels keep their results.
- R8: `busy` is high from the clock that accepts a corrected write until the clock that outputs its result, and also while a write waits in the holding slot. `busy` falls only on a clock that outputs a result.
- R9: A write that arrives while the engine is working and the holding slot is empty is held. It is processed after the current result, and the results come out in write order.
- R10: A write that arrives while the engine is working and the holding slot is full is discarded and produces no output.
- R11: A trim write with `trim_is_gain` = 0 loads the zero trim (twos complement). With `trim_is_gain` = 1 it loads the gain trim. Trims and the enable bit are sampled when a write starts, so a trim write on the same clock takes effect from the next write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Strobe that loads the correction enable bit |
| cfg_cal_en | input | 1 | New enable value: 1 corrects, 0 passes through |
| fmt_twos | input | 1 | 1: input codes are twos complement; 0: straight binary |
| trim_wr | input | 1 | Trim register write strobe |
| trim_is_gain | input | 1 | 0 selects the zero trim, 1 the gain trim |
| trim_ch | input | 3 | Channel of the trim write |
| trim_val | input | 16 | Trim value |
| in_vld | input | 1 | Code write strobe |
| in_ch | input | 3 | Channel of the code write |
| in_code | input | 16 | Code to write |
| out_vld | output | 1 | One-cycle strobe for a finished code |
| out_ch | output | 3 | Channel of the finished code |
| out_code | output | 16 | Finished (corrected or passed) code |
| busy | output | 1 | Engine working or a write held |

## Verification
The assertions assume that `cfg_wr` does not change the enable bit while writes are in flight. They check the pass-through timing only when a write arrives with `busy` low. They also assume `in_vld` is a plain level that is sampled every clock, with no handshake back. The stimulus changes the enable bit only after waiting for `busy` to drop and a few more cycles. It issues bursts of writes in consecutive cycles to fill and overflow the holding slot, and it mixes random trim writes with code writes at arbitrary times.

// File: rtl/cal_pkg.sv
package cal_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MUL  = 2'd1,
    ST_FIN  = 2'd2
  } eng_st_e;
endpackage

// File: rtl/cal_trim_bank.sv
module cal_trim_bank #(
  parameter int N_CH   = 8,
  parameter int CODE_W = 16,
  parameter int CH_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_is_gain,
  input  logic [CH_W-1:0]   wr_ch,
  input  logic [CODE_W-1:0] wr_val,
  input  logic [CH_W-1:0]   rd_ch,
  output logic [CODE_W-1:0] rd_zero,
  output logic [CODE_W-1:0] rd_gain
);
  logic [CODE_W-1:0] zero_arr [N_CH];
  logic [CODE_W-1:0] gain_arr [N_CH];

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    logic              hit;
    logic              zero_en, gain_en;
    logic [CODE_W-1:0] zero_q, gain_q;

    always_comb begin
      hit     = wr_en && (wr_ch == CH_W'(g));
      zero_en = hit && !wr_is_gain;
      gain_en = hit && wr_is_gain;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        zero_q <= '0;
        gain_q <= '1;
      end else begin
        if (zero_en) zero_q <= wr_val;
        if (gain_en) gain_q <= wr_val;
      end
    end

    assign zero_arr[g] = zero_q;
    assign gain_arr[g] = gain_q;
  end

  always_comb begin
    rd_zero = zero_arr[rd_ch];
    rd_gain = gain_arr[rd_ch];
  end
endmodule

// File: rtl/cal_mult.sv
module cal_mult #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         step,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] prod_hi
);
  localparam int PW = 2 * W;

  logic [PW-1:0] acc_q, acc_n;
  logic [PW-1:0] mcand_q, mcand_n;
  logic [W-1:0]  mplier_q, mplier_n;

  // acc starts at a so the finished product is a * (b + 1)
  always_comb begin
    acc_n    = acc_q;
    mcand_n  = mcand_q;
    mplier_n = mplier_q;
    if (load) begin
      acc_n    = {{W{1'b0}}, a};
      mcand_n  = {{W{1'b0}}, a};
      mplier_n = b;
    end else if (step) begin
      if (mplier_q[0]) acc_n = acc_q + mcand_q;
      mcand_n  = mcand_q << 1;
      mplier_n = mplier_q >> 1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q    <= '0;
      mcand_q  <= '0;
      mplier_q <= '0;
    end else if (load || step) begin
      acc_q    <= acc_n;
      mcand_q  <= mcand_n;
      mplier_q <= mplier_n;
    end
  end

  assign prod_hi = acc_q[PW-1:W];
endmodule

// File: rtl/cal_sat_add.sv
module cal_sat_add #(
  parameter int W = 16
) (
  input  logic [W-1:0] scaled,
  input  logic [W-1:0] zero,
  output logic [W-1:0] result
);
  logic signed [W+1:0] sum;

  always_comb begin
    sum = $signed({2'b00, scaled}) + $signed({{2{zero[W-1]}}, zero});
    if (sum[W+1])      result = '0;
    else if (sum[W])   result = '1;
    else               result = sum[W-1:0];
  end
endmodule

// File: rtl/cal_corr_engine.sv
module cal_corr_engine
  import cal_pkg::*;
#(
  parameter int N_CH   = 8,
  parameter int CODE_W = 16,
  parameter int CH_W   = (N_CH > 1) ? $clog2(N_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic              cfg_cal_en,
  input  logic              fmt_twos,
  input  logic              trim_wr,
  input  logic              trim_is_gain,
  input  logic [CH_W-1:0]   trim_ch,
  input  logic [CODE_W-1:0] trim_val,
  input  logic              in_vld,
  input  logic [CH_W-1:0]   in_ch,
  input  logic [CODE_W-1:0] in_code,
  output logic              out_vld,
  output logic [CH_W-1:0]   out_ch,
  output logic [CODE_W-1:0] out_code,
  output logic              busy
);
  localparam int                CNT_W    = (CODE_W > 1) ? $clog2(CODE_W) : 1;
  localparam logic [CNT_W-1:0]  CNT_LAST = CNT_W'(CODE_W - 1);
  localparam logic [CODE_W-1:0] MSB_MASK = {1'b1, {(CODE_W-1){1'b0}}};

  logic              cal_en_q;
  eng_st_e           st_q, st_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic              hold_vld_q, hold_vld_n;
  logic [CH_W-1:0]   hold_ch_q, hold_ch_n;
  logic [CODE_W-1:0] hold_code_q, hold_code_n;
  logic [CH_W-1:0]   eng_ch_q;
  logic [CODE_W-1:0] eng_zero_q;
  logic              out_vld_q, out_vld_n;
  logic [CH_W-1:0]   out_ch_q, out_ch_n;
  logic [CODE_W-1:0] out_code_q, out_code_n;

  logic [CODE_W-1:0] in_conv;
  logic              eng_idle, eng_busy, eng_fin;
  logic              src_vld, start_cal, start_byp;
  logic [CH_W-1:0]   src_ch;
  logic [CODE_W-1:0] src_code;
  logic [CODE_W-1:0] rd_zero, rd_gain, scaled, sat_res;

  // format conversion at the port
  always_comb in_conv = fmt_twos ? (in_code ^ MSB_MASK) : in_code;

  always_comb begin
    eng_idle  = (st_q == ST_IDLE);
    eng_busy  = !eng_idle;
    eng_fin   = (st_q == ST_FIN);
    src_vld   = eng_idle && (hold_vld_q || in_vld);
    src_ch    = hold_vld_q ? hold_ch_q   : in_ch;
    src_code  = hold_vld_q ? hold_code_q : in_conv;
    start_cal = src_vld && cal_en_q;
    start_byp = src_vld && !cal_en_q;
  end

  cal_trim_bank #(.N_CH(N_CH), .CODE_W(CODE_W), .CH_W(CH_W)) u_trim (
    .clk(clk), .rst_n(rst_n),
    .wr_en(trim_wr), .wr_is_gain(trim_is_gain), .wr_ch(trim_ch), .wr_val(trim_val),
    .rd_ch(src_ch), .rd_zero(rd_zero), .rd_gain(rd_gain)
  );

  cal_mult #(.W(CODE_W)) u_mult (
    .clk(clk), .rst_n(rst_n),
    .load(start_cal), .step(st_q == ST_MUL),
    .a(src_code), .b(rd_gain), .prod_hi(scaled)
  );

  cal_sat_add #(.W(CODE_W)) u_sat (
    .scaled(scaled), .zero(eng_zero_q), .result(sat_res)
  );

  // engine sequencing
  always_comb begin
    st_n  = st_q;
    cnt_n = cnt_q;
    unique case (st_q)
      ST_IDLE: if (start_cal) begin
        st_n  = ST_MUL;
        cnt_n = '0;
      end
      ST_MUL: begin
        if (cnt_q == CNT_LAST) st_n = ST_FIN;
        else                   cnt_n = cnt_q + 1'b1;
      end
      ST_FIN:  st_n = ST_IDLE;
      default: st_n = ST_IDLE;
    endcase
  end

  // holding slot: fills while the engine works, drains when idle
  always_comb begin
    hold_vld_n  = hold_vld_q;
    hold_ch_n   = hold_ch_q;
    hold_code_n = hold_code_q;
    if (eng_idle) begin
      hold_vld_n = hold_vld_q && in_vld;
      if (hold_vld_q && in_vld) begin
        hold_ch_n   = in_ch;
        hold_code_n = in_conv;
      end
    end else if (!hold_vld_q && in_vld) begin
      hold_vld_n  = 1'b1;
      hold_ch_n   = in_ch;
      hold_code_n = in_conv;
    end
  end

  always_comb begin
    out_vld_n  = start_byp || eng_fin;
    out_ch_n   = eng_fin ? eng_ch_q : src_ch;
    out_code_n = eng_fin ? sat_res  : src_code;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cal_en_q    <= 1'b0;
      st_q        <= ST_IDLE;
      cnt_q       <= '0;
      hold_vld_q  <= 1'b0;
      hold_ch_q   <= '0;
      hold_code_q <= '0;
      eng_ch_q    <= '0;
      eng_zero_q  <= '0;
      out_vld_q   <= 1'b0;
      out_ch_q    <= '0;
      out_code_q  <= '0;
    end else begin
      if (cfg_wr) cal_en_q <= cfg_cal_en;
      st_q       <= st_n;
      cnt_q      <= cnt_n;
      hold_vld_q <= hold_vld_n;
      if (hold_vld_n) begin
        hold_ch_q   <= hold_ch_n;
        hold_code_q <= hold_code_n;
      end
      if (start_cal) begin
        eng_ch_q   <= src_ch;
        eng_zero_q <= rd_zero;
      end
      out_vld_q <= out_vld_n;
      if (out_vld_n) begin
        out_ch_q   <= out_ch_n;
        out_code_q <= out_code_n;
      end
    end
  end

  always_comb begin
    out_vld  = out_vld_q;
    out_ch   = out_ch_q;
    out_code = out_code_q;
    busy     = eng_busy || hold_vld_q;
  end
endmodule

// File: rtl/cal_corr_checker.sv
module cal_corr_checker #(
  parameter int CODE_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_vld,
  input logic [CODE_W-1:0] in_code,
  input logic              fmt_twos,
  input logic              out_vld,
  input logic [CODE_W-1:0] out_code,
  input logic              busy,
  input logic              cal_en,
  input logic              eng_busy,
  input logic              eng_fin,
  input logic              start_cal,
  input logic              hold_vld,
  input logic [CODE_W-1:0] hold_code
);
  localparam int                LAT   = CODE_W + 1;
  localparam int                LAT_W = $clog2(LAT + 2) + 1;
  localparam logic [CODE_W-1:0] MSB   = {1'b1, {(CODE_W-1){1'b0}}};

  logic [LAT_W-1:0] lat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             lat_q <= '0;
    else if (start_cal)     lat_q <= LAT_W'(1);
    else if (eng_fin)       lat_q <= '0;
    else if (lat_q != '0)   lat_q <= lat_q + 1'b1;
  end

  assert_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
    eng_fin |-> (lat_q == LAT_W'(LAT)));

  assert_busy_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> out_vld);

  assert_bypass_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && !busy && !cal_en) |=>
      (out_vld && out_code == ($past(fmt_twos) ? ($past(in_code) ^ MSB) : $past(in_code))));

  assert_hold_fill_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_busy && !hold_vld && in_vld) |=> hold_vld);

  assert_hold_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_busy && hold_vld && in_vld) |=> (hold_vld && $stable(hold_code)));
endmodule

bind cal_corr_engine cal_corr_checker #(.CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_code(in_code),
  .fmt_twos(fmt_twos), .out_vld(out_vld), .out_code(out_code), .busy(busy),
  .cal_en(cal_en_q), .eng_busy(eng_busy), .eng_fin(eng_fin),
  .start_cal(start_cal), .hold_vld(hold_vld_q), .hold_code(hold_code_q)
);

// File: tb/cal_corr_engine_bench.sv
`timescale 1ns/1ps
module cal_corr_engine_bench;
  logic        clk, rst_n;
  logic        cfg_wr, cfg_cal_en, fmt_twos;
  logic        trim_wr, trim_is_gain;
  logic [2:0]  trim_ch;
  logic [15:0] trim_val;
  logic        in_vld;
  logic [2:0]  in_ch;
  logic [15:0] in_code;
  logic        out_vld, busy;
  logic [2:0]  out_ch;
  logic [15:0] out_code;

  cal_corr_engine u_cal_corr_engine (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_cal_en(cfg_cal_en),
    .fmt_twos(fmt_twos), .trim_wr(trim_wr), .trim_is_gain(trim_is_gain),
    .trim_ch(trim_ch), .trim_val(trim_val), .in_vld(in_vld), .in_ch(in_ch),
    .in_code(in_code), .out_vld(out_vld), .out_ch(out_ch), .out_code(out_code),
    .busy(busy)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int    n_checks = 0;
  int    n_fails  = 0;
  string cur_req  = "R1";
  int    cyc      = 0;
  bit    done     = 0;

  // behavioural reference model
  int m_zero [8];
  int m_gain [8];
  bit m_en;
  int hq [$];
  int eng_left;
  int eng_res;
  int eng_ch;
  bit exp_vld;
  int exp_ch, exp_code;
  bit exp_busy;

  function automatic int corr(int x, int g, int z);
    longint p, s;
    p = longint'(x) * longint'(g + 1);
    s = (p >>> 16) + longint'(z >= 32768 ? z - 65536 : z);
    if (s > 65535) s = 65535;
    if (s < 0)     s = 0;
    return int'(s);
  endfunction

  always @(posedge clk) begin
    int item, cin;
    bit ok;
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) begin m_zero[i] = 0; m_gain[i] = 65535; end
      m_en = 0; hq.delete(); eng_left = 0; exp_vld = 0; exp_busy = 0;
    end else begin
      exp_vld = 0;
      ok = 0;
      item = 0;
      cin = int'(in_code) ^ (fmt_twos ? 32768 : 0);
      if (eng_left > 0) begin
        eng_left--;
        if (eng_left == 0) begin
          exp_vld = 1; exp_ch = eng_ch; exp_code = eng_res;
        end
        if (in_vld && hq.size() == 0) hq.push_back(int'(in_ch) * 65536 + cin);
      end else begin
        if (hq.size() > 0) begin
          item = hq.pop_front(); ok = 1;
          if (in_vld) hq.push_back(int'(in_ch) * 65536 + cin);
        end else if (in_vld) begin
          item = int'(in_ch) * 65536 + cin; ok = 1;
        end
        if (ok) begin
          if (m_en) begin
            eng_left = 17;
            eng_ch   = item / 65536;
            eng_res  = corr(item % 65536, m_gain[item / 65536], m_zero[item / 65536]);
          end else begin
            exp_vld = 1; exp_ch = item / 65536; exp_code = item % 65536;
          end
        end
      end
      if (cfg_wr) m_en = cfg_cal_en;
      if (trim_wr) begin
        if (trim_is_gain) m_gain[trim_ch] = int'(trim_val);
        else              m_zero[trim_ch] = int'(trim_val);
      end
      exp_busy = (eng_left > 0) || (hq.size() > 0);
    end
  end

  // comparison every cycle, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      n_checks++;
      if (!rst_n) begin
        if (out_vld !== 1'b0 || busy !== 1'b0) begin
          n_fails++;
          $display("FAIL R1 reset: out_vld=%0b busy=%0b expected 0 0", out_vld, busy);
        end
      end else begin
        if (out_vld !== exp_vld) begin
          n_fails++;
          $display("FAIL %s out_vld=%0b expected %0b (cycle %0d)", cur_req, out_vld, exp_vld, cyc);
        end else if (exp_vld && (int'(out_ch) != exp_ch || int'(out_code) != exp_code)) begin
          n_fails++;
          $display("FAIL %s ch/code=%0d/%h expected %0d/%h (cycle %0d)",
                   cur_req, out_ch, out_code, exp_ch, exp_code[15:0], cyc);
        end
        if (busy !== exp_busy) begin
          n_fails++;
          $display("FAIL R8 (%s) busy=%0b expected %0b (cycle %0d)", cur_req, busy, exp_busy, cyc);
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      n_fails++;
      $display("FAIL watchdog expired: cycle %0d expected completion", cyc);
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  task automatic write_code(input logic [2:0] ch, input logic [15:0] code, input bit twos);
    @(negedge clk);
    in_vld = 1; in_ch = ch; in_code = code; fmt_twos = twos;
    @(negedge clk);
    in_vld = 0; fmt_twos = 0;
  endtask

  task automatic write_trim(input logic [2:0] ch, input bit is_gain, input logic [15:0] v);
    @(negedge clk);
    trim_wr = 1; trim_ch = ch; trim_is_gain = is_gain; trim_val = v;
    @(negedge clk);
    trim_wr = 0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 200 && busy; i++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic set_enable(input bit en);
    wait_idle();
    @(negedge clk);
    cfg_wr = 1; cfg_cal_en = en;
    @(negedge clk);
    cfg_wr = 0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    rst_n = 0; cfg_wr = 0; cfg_cal_en = 0; fmt_twos = 0;
    trim_wr = 0; trim_is_gain = 0; trim_ch = 0; trim_val = 0;
    in_vld = 0; in_ch = 0; in_code = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);

    cur_req = "R2";  // pass-through, back to back
    @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      in_vld = 1; in_ch = 3'(i * 3); in_code = 16'h1234 + 16'(i * 16'h1111); fmt_twos = 0;
      @(negedge clk);
    end
    in_vld = 0;
    repeat (3) @(negedge clk);

    cur_req = "R3";  // bit 15 inverted for twos complement
    write_code(3'd1, 16'h8000, 1);
    write_code(3'd2, 16'h7FFF, 1);
    write_code(3'd5, 16'h0000, 1);
    repeat (3) @(negedge clk);

    cur_req = "R1";  // default trims give unity through the engine
    set_enable(1);
    write_code(3'd0, 16'hABCD, 0);
    wait_idle();

    cur_req = "R11"; // zero trim select 0, gain trim select 1
    write_trim(3'd2, 1'b1, 16'h7FFF);
    write_trim(3'd2, 1'b0, 16'h0010);
    cur_req = "R4";
    write_code(3'd2, 16'h8000, 0);
    wait_idle();
    write_code(3'd2, 16'h0001, 1);
    wait_idle();

    cur_req = "R7";  // channel 3 keeps its unity trims
    write_code(3'd3, 16'h4321, 0);
    wait_idle();

    cur_req = "R5";
    write_trim(3'd4, 1'b0, 16'h7FFF);
    write_code(3'd4, 16'hFFFF, 0);
    wait_idle();
    cur_req = "R6";
    write_trim(3'd5, 1'b0, 16'h8000);
    write_code(3'd5, 16'h0100, 0);
    wait_idle();

    cur_req = "R9";  // three writes in consecutive cycles
    @(negedge clk);
    in_vld = 1; in_ch = 3'd6; in_code = 16'h1000; @(negedge clk);
    in_ch = 3'd7; in_code = 16'h2000;            @(negedge clk);
    cur_req = "R10";
    in_ch = 3'd1; in_code = 16'h3000;            @(negedge clk);
    in_vld = 0;
    wait_idle();

    cur_req = "R8";  // write arriving on the finishing cycle
    write_code(3'd0, 16'h5555, 0);
    repeat (15) @(negedge clk);
    write_code(3'd1, 16'h6666, 0);
    wait_idle();

    cur_req = "R4";  // random mix
    for (int k = 0; k < 60; k++) begin
      if (k % 15 == 0) set_enable(1'($urandom_range(0, 1)));
      @(negedge clk);
      in_vld   = 1'($urandom_range(0, 2) != 0);
      in_ch    = 3'($urandom);
      in_code  = 16'($urandom);
      fmt_twos = 1'($urandom);
      trim_wr  = 1'($urandom_range(0, 3) == 0);
      trim_ch  = 3'($urandom);
      trim_is_gain = 1'($urandom);
      trim_val = 16'($urandom);
      @(negedge clk);
      in_vld = 0; trim_wr = 0; fmt_twos = 0;
      repeat ($urandom_range(0, 20)) @(negedge clk);
    end
    wait_idle();

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule